// File: doc/BRIEF.md
# Interrupt-capable GPIO bank

A bank of up to 32 general-purpose pins behind a small 32-bit register bus. Software chooses for each pin whether it is an input or an output, sets output levels, and reads back the pin states. Every pin also has an interrupt detector. The detector can be set to a level or to a single edge, with a polarity select for each pin. Its hits are held in a status latch. The enabled part of that latch is combined into one interrupt line to the host.

Pin inputs pass through a two-flop synchronizer before they reach detection or read-back. Status bits are cleared by writing ones to a dedicated clear word. A level condition that persists re-arms its bit on the next clock edge, so a level source must be removed at the pin before its bit can be cleared. Bus reads are combinational. A write takes effect on the clock edge that samples it.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every pin is an input (direction word all ones), output data is 0, all interrupt enables are 0, `pin_oe` is 0 and `irq` is low.
- R2: Direction word (word index 1): bit n = 1 makes pin n an input and bit n = 0 an output. `pin_oe` bit n is the inverse of direction bit n, and `pin_out` carries the output data word (written at word index 0).
- R3: A read of word index 0 returns the output data bit for output pins and the synchronized pin level for input pins. A change at `pin_in` becomes visible on the second rising clock edge after it.
- R4: With mode bit (word 6) = 1 and polarity bit (word 7) = 0, a pin sets its status bit once for each rising edge, and does not set it on falling edges. The bit is set on the third clock edge after the pin changes.
- R5: With mode bit = 1 and polarity bit = 1, only falling edges set the status bit.
- R6: With mode bit = 0, polarity bit = 1 flags a high pin and polarity bit = 0 flags a low pin.
- R7: A level condition that still holds sets its status bit again on every clock, so a clear has no lasting effect while the condition holds.
- R8: Writing word index 5 clears each status bit whose data bit is 1 and leaves the bits written 0 untouched. Status bits fall only through this write.
- R9: If a detection and a clear hit the same bit on the same clock edge, the bit ends up set.
- R10: Word index 4 reads status AND enable (enable is word 2), and `irq` is the OR of those bits. With all enables 0, `irq` stays low.
- R11: Word index 3 reads the raw status. Writes to words 3 and 4 are ignored, and word 5 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_word |
| pin_in | input | NPIN | Pad input levels |
| pin_out | output | NPIN | Pad output levels |
| pin_oe | output | NPIN | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench makes a clear write and a freshly detected edge meet on the same clock. A design that gives the clear priority would lose that interrupt. It clears a level-high source while the pin is still high: a bank that latched levels once would report the bit gone. It drives edges in the non-selected direction to catch a detector that fires on both edges or has the polarity sense reversed. It also reads pin state one and two cycles after a change, which exposes a synchronizer that is too short or too long. Writes to the read-only status and pending words, and clear writes with zero bits, must leave the status intact.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [2:0]      bus_word,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);

  localparam logic [2:0] W_VAL = 3'd0, W_DIR = 3'd1, W_IEN = 3'd2, W_STS = 3'd3,
                         W_PND = 3'd4, W_CLR = 3'd5, W_MODE = 3'd6, W_POL = 3'd7;

  logic [NPIN-1:0] s1, s2, s3;
  logic [NPIN-1:0] out_q, dir_q, ien_q, mode_q, pol_q, sts_q;
  logic [NPIN-1:0] wd, rise, fall, hit, clr_m, pend;
  logic            wr_en;

  assign wd    = bus_wdata[NPIN-1:0];
  assign wr_en = bus_sel & bus_wr;
  assign clr_m = (wr_en && bus_word == W_CLR) ? wd : '0;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign hit  = (mode_q & ((pol_q & fall) | (~pol_q & rise)))
              | (~mode_q & ((pol_q & s2) | (~pol_q & ~s2)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      ien_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      case (bus_word)
        W_VAL:   out_q  <= wd;
        W_DIR:   dir_q  <= wd;
        W_IEN:   ien_q  <= wd;
        W_MODE:  mode_q <= wd;
        W_POL:   pol_q  <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_m) | hit;
  end

  assign pend    = sts_q & ien_q;
  assign irq     = |pend;
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    case (bus_word)
      W_VAL:   bus_rdata = 32'((dir_q & s2) | (~dir_q & out_q));
      W_DIR:   bus_rdata = 32'(dir_q);
      W_IEN:   bus_rdata = 32'(ien_q);
      W_STS:   bus_rdata = 32'(sts_q);
      W_PND:   bus_rdata = 32'(pend);
      W_MODE:  bus_rdata = 32'(mode_q);
      W_POL:   bus_rdata = 32'(pol_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [2:0]      bus_word,
  input logic [31:0]     bus_wdata,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] sts_q,
  input logic [NPIN-1:0] ien_q
);

  logic [NPIN-1:0] clr_seen;
  assign clr_seen = (bus_sel && bus_wr && bus_word == 3'd5) ? bus_wdata[NPIN-1:0] : '0;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ien_q == '0 && !irq && pin_oe == '0));

  a_r2_dir_write_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_word == 3'd1) |=> (pin_oe == ~$past(bus_wdata[NPIN-1:0])));

  a_r8_status_falls_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~sts_q & $past(sts_q) & ~$past(clr_seen)) == '0));

  a_r10_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_word(bus_word), .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq),
  .sts_q(sts_q), .ien_q(ien_q)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  localparam int NPIN = 32;
  localparam int NV = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_word = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPIN-1:0] pin_in = '1, pin_out, pin_oe;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NPIN(NPIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write, byte offset, data, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h04, 32'h0000FFFF, 32'h0},          // R2
    {1'b0, 8'h04, 32'h0,        32'h0000FFFF},   // R2
    {1'b1, 8'h00, 32'hA5A50000, 32'h0},          // R3
    {1'b0, 8'h00, 32'h0,        32'hA5A5FFFF},   // R3
    {1'b1, 8'h08, 32'h12345678, 32'h0},
    {1'b0, 8'h08, 32'h0,        32'h12345678},
    {1'b1, 8'h0C, 32'hFFFFFFFF, 32'h0},          // R11
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0},          // R11
    {1'b0, 8'h0C, 32'h0,        32'h00000000},   // R11
    {1'b0, 8'h14, 32'h0,        32'h00000000},   // R11
    {1'b1, 8'h18, 32'hFFFFFFFF, 32'h0},
    {1'b1, 8'h1C, 32'h0000FFFF, 32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h00000000},   // R4 R5 stable pins
    {1'b1, 8'h18, 32'h00000000, 32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h0000FFFF},   // R6
    {1'b0, 8'h10, 32'h0,        32'h00005678},   // R10
    {1'b1, 8'h14, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h0000FFFF},   // R7
    {1'b1, 8'h1C, 32'h00000000, 32'h0},
    {1'b1, 8'h14, 32'h0000000F, 32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h0000FFF0},   // R8
    {1'b1, 8'h14, 32'h00000000, 32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h0000FFF0},   // R8 zeros
    {1'b1, 8'h14, 32'hFFFFFFFF, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = off[4:2]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_word = off[4:2];
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    cyc(3);
    rd(8'h04, r);             check("R1 dir", r, 32'hFFFFFFFF);
    rd(8'h08, r);             check("R1 ien", r, 32'h0);
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    cyc(5);
    wr(8'h14, 32'hFFFFFFFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], r);
        check($sformatf("R2-11 vector %0d", i), r, VEC[i][31:0]);
      end
    end
    wr(8'h08, 32'h0); wr(8'h04, 32'hFFFFFFFF); wr(8'h00, 32'h0);

    // R2 pad controls
    wr(8'h04, 32'hFFFFFF00); wr(8'h00, 32'h000000C3);
    check("R2 oe", pin_oe, 32'h000000FF);
    check("R2 out", pin_out, 32'h000000C3);
    wr(8'h04, 32'hFFFFFFFF);

    // R3 sync latency
    @(negedge clk); pin_in[4] = 1'b0;
    rd(8'h00, r); check("R3 one edge", {31'b0, r[4]}, 32'h1);
    rd(8'h00, r); check("R3 two edges", {31'b0, r[4]}, 32'h0);
    pin_in[4] = 1'b1;
    cyc(3);

    // R10 / R7 level high on pin 0
    wr(8'h1C, 32'h1);
    rd(8'h0C, r); check("R6 level high", {31'b0, r[0]}, 32'h1);
    check("R10 masked irq", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    check("R10 irq", {31'b0, irq}, 32'h1);
    rd(8'h10, r); check("R10 pend", r, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h0C, r); check("R7 re-arm", {31'b0, r[0]}, 32'h1);
    wr(8'h1C, 32'h0); wr(8'h14, 32'hFFFFFFFF);
    cyc(1);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h0);

    // R4 / R5 edges: pin1 rising, pin2 falling
    wr(8'h18, 32'h6); wr(8'h1C, 32'h4); wr(8'h14, 32'hFFFFFFFF);
    @(negedge clk); pin_in[1] = 1'b0; cyc(4);
    rd(8'h0C, r); check("R4 no fall", {31'b0, r[1]}, 32'h0);
    pin_in[1] = 1'b1; cyc(4);
    rd(8'h0C, r); check("R4 rise", {31'b0, r[1]}, 32'h1);
    wr(8'h14, 32'h2); cyc(3);
    rd(8'h0C, r); check("R4 one shot", {31'b0, r[1]}, 32'h0);
    pin_in[2] = 1'b0; cyc(4);
    rd(8'h0C, r); check("R5 fall", {31'b0, r[2]}, 32'h1);
    wr(8'h14, 32'h4);
    @(negedge clk); pin_in[2] = 1'b1; cyc(4);
    rd(8'h0C, r); check("R5 no rise", {31'b0, r[2]}, 32'h0);

    // R9 clear meets detect on the same edge
    pin_in[1] = 1'b0; cyc(4);
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 3'd5; bus_wdata = 32'h2;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h0C, r); check("R9 detect wins", {31'b0, r[1]}, 32'h1);
    wr(8'h14, 32'h2);
    rd(8'h0C, r); check("R8 plain clear", {31'b0, r[1]}, 32'h0);

    // R6 level low on pin 3
    @(negedge clk); pin_in[3] = 1'b0; cyc(4);
    rd(8'h0C, r); check("R6 level low", {31'b0, r[3]}, 32'h1);
    pin_in[3] = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule